// File: doc/BRIEF.md
# High-Register ALU and Branch-Exchange Unit

This unit executes one class of 16-bit compressed instructions: add, compare and move between any two of sixteen 32-bit registers, plus a branch that can also switch the processor between its compressed and full-width instruction sets. A 3-bit register field, extended by a one-bit high flag, names each operand. The unit holds the register file, where entry 15 is the program counter. It also holds the N/Z/C/V condition flags and the instruction-set state bit.

One instruction word arrives with a valid strobe in each cycle. The unit decodes the word and updates its state on that same clock edge. In the following cycle it reports three results: a one-cycle branch-taken pulse with its target, an undefined-encoding pulse, or neither. A combinational debug port reads any register.

The instruction-set state is a two-state machine. `ST_COMPACT` (the reset state) moves to `ST_FULL` on the transition "to-full", which is a branch-exchange whose source value has bit 0 clear. `ST_FULL` moves to `ST_COMPACT` on the transition "to-compact", which is a branch-exchange whose source value has bit 0 set. Every other cycle is a self-loop: "hold-compact" or "hold-full". Instructions are executed in either state.

Top module: `hrx_top`

## Requirements
- R1: A word is ignored when its bits 15:10 differ from 010001, or when `instr_valid` is low. An ignored word changes no register, flag or state, and raises neither `branch_taken` nor `undef_flag`.
- R2: The word's fields are read as follows. Bits 9:8 are the operation code. The destination index is {bit 7, bits 2:0} and the source index is {bit 6, bits 5:3}, so a set high flag selects registers 8-15.
- R3: Operation code 00 writes destination + source, modulo 2^32, into the destination.
- R4: Operation code 10 writes the source value into the destination.
- R5: Operation code 01 computes destination − source and leaves every register unchanged. It sets `flags_nzcv` as follows: bit 3 is N (result bit 31), bit 2 is Z (result is zero), bit 1 is C (no borrow, i.e. destination ≥ source unsigned) and bit 0 is V (signed overflow of the subtraction).
- R6: Operation codes 00, 10 and 11 leave `flags_nzcv` unchanged.
- R7: Operation codes 00, 01 and 10 with both high flags clear are undefined. Such a word raises `undef_flag` for the next cycle and changes no register or flag.
- R8: Operation code 11 is the branch-exchange. It takes the source value and sets the new state to its bit 0 (`state_compact` = 1 means compressed, 0 means full-width). It loads register 15 with that value, with bit 0 cleared and, when full-width is entered, with bit 1 cleared as well. It raises `branch_taken`, with `branch_target` equal to the new register 15.
- R9: When register 15 is read as an operand, the value used is its stored value + PC_AHEAD (default 4). The debug port returns the stored value.
- R10: When an add or a move writes register 15, bit 0 of the written value is cleared. The instruction raises `branch_taken`, with `branch_target` equal to that value.
- R11: A synchronous reset clears every register and the flags, sets `state_compact` to 1 and drops `branch_taken` and `undef_flag`.
- R12: Register, flag and state updates are visible right after the edge on which the strobe is sampled. `branch_taken` and `undef_flag` are high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| dbg_sel | input | 4 | Debug register index |
| dbg_data | output | XLEN | Stored value of register `dbg_sel` |
| flags_nzcv | output | 4 | Condition flags {N,Z,C,V} |
| state_compact | output | 1 | 1 = compressed instruction-set state |
| branch_taken | output | 1 | One-cycle branch pulse |
| branch_target | output | XLEN | Target of the last branch |
| undef_flag | output | 1 | One-cycle undefined-encoding pulse |

## Verification
The bench builds two copies of the unit side by side and drives both with the same stimulus. One copy uses the default PC_AHEAD of 4. The other uses PC_AHEAD of 5, because with a look-ahead of 4 every reachable register value is even. The odd look-ahead is therefore what brings the "to-compact" transition, the bit-0 clearing on writes to the program counter, and the bit-1 clearing on entry to full-width state within reach. On both copies the bench sweeps all 1024 encodings of the class, with arithmetic models tracking each register file, and it also runs all 63 foreign prefixes.

// File: rtl/hrx_pkg.sv
`timescale 1ns/1ps
package hrx_pkg;
    localparam int unsigned RIDX_W = 4;
    localparam int unsigned NREG = 1 << RIDX_W;
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);
    localparam logic [5:0] CLASS_TAG = 6'b010001;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_CMP = 2'b01,
        OP_MOV = 2'b10,
        OP_BXC = 2'b11
    } hrx_op_e;

    typedef enum logic {
        ST_FULL    = 1'b0,
        ST_COMPACT = 1'b1
    } hrx_state_e;

    typedef struct packed {
        logic              hit;
        logic              undef;
        hrx_op_e           op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
    } hrx_dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } hrx_flags_t;
endpackage

// File: rtl/hrx_decode.sv
`timescale 1ns/1ps
module hrx_decode
    import hrx_pkg::*;
(
    input  logic        valid,
    input  logic [15:0] word,
    output hrx_dec_t    dec
);
    logic tag_ok;
    logic lo_lo;

    always_comb begin
        tag_ok    = valid && (word[15:10] == CLASS_TAG);
        lo_lo     = !word[7] && !word[6];
        dec.hit   = tag_ok;
        dec.op    = hrx_op_e'(word[9:8]);
        dec.rd    = {word[7], word[2:0]};
        dec.rs    = {word[6], word[5:3]};
        dec.undef = tag_ok && lo_lo && (word[9:8] != 2'b11);
    end
endmodule

// File: rtl/hrx_regfile.sv
`timescale 1ns/1ps
module hrx_regfile
    import hrx_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned PC_AHEAD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd,
    input  logic [RIDX_W-1:0] ra_a,
    output logic [XLEN-1:0]   rd_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [XLEN-1:0]   rd_b,
    input  logic [RIDX_W-1:0] dbg_a,
    output logic [XLEN-1:0]   dbg_d
);
    localparam logic [XLEN-1:0] AHEAD = XLEN'(PC_AHEAD);

    logic [NREG-1:0][XLEN-1:0] rq;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (wa == RIDX_W'(g))) begin
                q <= wd;
            end
        end
        assign rq[g] = q;
    end

    function automatic logic [XLEN-1:0] opnd(input logic [RIDX_W-1:0] idx,
                                             input logic [NREG-1:0][XLEN-1:0] arr);
        if (idx == PC_IDX) begin
            return arr[PC_IDX] + AHEAD;
        end
        return arr[idx];
    endfunction

    always_comb begin
        rd_a  = opnd(ra_a, rq);
        rd_b  = opnd(ra_b, rq);
        dbg_d = rq[dbg_a];
    end
endmodule

// File: rtl/hrx_alu.sv
`timescale 1ns/1ps
module hrx_alu
    import hrx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  hrx_dec_t          dec,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              we,
    output logic [RIDX_W-1:0] wa,
    output logic [XLEN-1:0]   wd,
    output logic              flags_we,
    output hrx_flags_t        flags_nx,
    output logic              br,
    output logic [XLEN-1:0]   br_tgt,
    output logic              st_we,
    output hrx_state_e        st_nx
);
    localparam int unsigned MSB = XLEN - 1;

    logic [XLEN-1:0] sum;
    logic [XLEN:0]   diff;
    logic [XLEN-1:0] res;

    always_comb begin
        sum      = a + b;
        diff     = {1'b0, a} - {1'b0, b};
        res      = '0;
        we       = 1'b0;
        wa       = dec.rd;
        flags_we = 1'b0;
        flags_nx = '0;
        br       = 1'b0;
        br_tgt   = '0;
        st_we    = 1'b0;
        st_nx    = ST_COMPACT;
        if (dec.hit && !dec.undef) begin
            unique case (dec.op)
                OP_ADD, OP_MOV: begin
                    res = (dec.op == OP_ADD) ? sum : b;
                    if (dec.rd == PC_IDX) begin
                        res[0] = 1'b0;
                        br     = 1'b1;
                        br_tgt = res;
                    end
                    we = 1'b1;
                end
                OP_CMP: begin
                    flags_we   = 1'b1;
                    flags_nx.n = diff[MSB];
                    flags_nx.z = (diff[MSB:0] == '0);
                    flags_nx.c = !diff[XLEN];
                    flags_nx.v = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
                end
                OP_BXC: begin
                    st_we  = 1'b1;
                    st_nx  = b[0] ? ST_COMPACT : ST_FULL;
                    res    = b;
                    res[0] = 1'b0;
                    if (!b[0]) begin
                        res[1] = 1'b0;
                    end
                    br     = 1'b1;
                    br_tgt = res;
                    we     = 1'b1;
                    wa     = PC_IDX;
                end
                default: ;
            endcase
        end
        wd = res;
    end
endmodule

// File: rtl/hrx_top.sv
`timescale 1ns/1ps
module hrx_top
    import hrx_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned PC_AHEAD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data,
    output logic [3:0]        flags_nzcv,
    output logic              state_compact,
    output logic              branch_taken,
    output logic [XLEN-1:0]   branch_target,
    output logic              undef_flag
);
    hrx_dec_t          dec;
    logic [XLEN-1:0]   op_a;
    logic [XLEN-1:0]   op_b;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic [XLEN-1:0]   rf_wd;
    logic              fl_we;
    hrx_flags_t        fl_nx;
    hrx_flags_t        fl_q;
    logic              br;
    logic [XLEN-1:0]   br_tgt;
    logic              st_we;
    hrx_state_e        st_nx;
    hrx_state_e        state_q;
    hrx_state_e        state_d;

    hrx_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .dec   (dec)
    );

    hrx_regfile #(
        .XLEN     (XLEN),
        .PC_AHEAD (PC_AHEAD)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd),
        .ra_a  (dec.rd),
        .rd_a  (op_a),
        .ra_b  (dec.rs),
        .rd_b  (op_b),
        .dbg_a (dbg_sel),
        .dbg_d (dbg_data)
    );

    hrx_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .dec      (dec),
        .a        (op_a),
        .b        (op_b),
        .we       (rf_we),
        .wa       (rf_wa),
        .wd       (rf_wd),
        .flags_we (fl_we),
        .flags_nx (fl_nx),
        .br       (br),
        .br_tgt   (br_tgt),
        .st_we    (st_we),
        .st_nx    (st_nx)
    );

    // Condition flags
    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else if (fl_we) begin
            fl_q <= fl_nx;
        end
    end

    // Instruction-set state machine: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COMPACT;
        end else begin
            state_q <= state_d;
        end
    end

    // Instruction-set state machine: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COMPACT: if (st_we && (st_nx == ST_FULL))    state_d = ST_FULL;
            ST_FULL:    if (st_we && (st_nx == ST_COMPACT)) state_d = ST_COMPACT;
            default:    state_d = ST_COMPACT;
        endcase
    end

    // Event outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            branch_taken  <= 1'b0;
            branch_target <= '0;
            undef_flag    <= 1'b0;
        end else begin
            branch_taken <= br;
            undef_flag   <= dec.undef;
            if (br) begin
                branch_target <= br_tgt;
            end
        end
    end

    assign flags_nzcv    = fl_q;
    assign state_compact = (state_q == ST_COMPACT);
endmodule

// File: rtl/hrx_checker.sv
`timescale 1ns/1ps
module hrx_checker #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic [15:0]     instr_word,
    input logic [3:0]      flags_nzcv,
    input logic            state_compact,
    input logic            branch_taken,
    input logic [XLEN-1:0] branch_target,
    input logic            undef_flag
);
    logic tag_hit;
    logic is_bx;
    logic is_cmp;
    logic lo_lo;
    assign tag_hit = instr_valid && (instr_word[15:10] == 6'b010001);
    assign is_bx   = tag_hit && (instr_word[9:8] == 2'b11);
    assign is_cmp  = tag_hit && (instr_word[9:8] == 2'b01);
    assign lo_lo   = !instr_word[7] && !instr_word[6];

    assert_ignored_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !tag_hit |=> ($stable(flags_nzcv) && $stable(state_compact) && !branch_taken && !undef_flag));

    assert_flags_cmp_only_R6: assert property (@(posedge clk) disable iff (rst)
        !is_cmp |=> $stable(flags_nzcv));

    assert_undef_raised_R7: assert property (@(posedge clk) disable iff (rst)
        (tag_hit && !is_bx && lo_lo) |=> (undef_flag && !branch_taken && $stable(flags_nzcv)));

    assert_defined_no_undef_R7: assert property (@(posedge clk) disable iff (rst)
        (tag_hit && (is_bx || !lo_lo)) |=> !undef_flag);

    assert_bx_branches_R8: assert property (@(posedge clk) disable iff (rst)
        is_bx |=> (branch_taken && (state_compact ? !branch_target[0] : (branch_target[1:0] == 2'b00))));

    assert_state_bx_only_R8: assert property (@(posedge clk) disable iff (rst)
        !is_bx |=> $stable(state_compact));

    assert_target_even_R10: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> !branch_target[0]);

    assert_cmp_no_branch_R5: assert property (@(posedge clk) disable iff (rst)
        is_cmp |=> !branch_taken);
endmodule

bind hrx_top hrx_checker #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .instr_word    (instr_word),
    .flags_nzcv    (flags_nzcv),
    .state_compact (state_compact),
    .branch_taken  (branch_taken),
    .branch_target (branch_target),
    .undef_flag    (undef_flag)
);

// File: tb/hrx_top_tb_top.sv
`timescale 1ns/10ps
module hrx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [3:0]  dbg_sel;

    logic [31:0] dbg_d [2];
    logic [3:0]  fl    [2];
    logic        stc   [2];
    logic        brt   [2];
    logic [31:0] tgt   [2];
    logic        und   [2];

    logic [31:0] mreg [2][16];
    logic [3:0]  mfl  [2];
    logic        mst  [2];
    logic        e_br [2];
    logic [31:0] e_tgt [2];
    logic        e_und [2];

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    hrx_top dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .dbg_sel(dbg_sel), .dbg_data(dbg_d[0]), .flags_nzcv(fl[0]),
        .state_compact(stc[0]), .branch_taken(brt[0]), .branch_target(tgt[0]),
        .undef_flag(und[0])
    );

    hrx_top #(.PC_AHEAD(5)) dut_odd_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .dbg_sel(dbg_sel), .dbg_data(dbg_d[1]), .flags_nzcv(fl[1]),
        .state_compact(stc[1]), .branch_taken(brt[1]), .branch_target(tgt[1]),
        .undef_flag(und[1])
    );

    function automatic logic [31:0] ahead(input int k);
        return (k == 0) ? 32'd4 : 32'd5;
    endfunction

    function automatic logic [15:0] enc(input logic [1:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs);
        return {6'b010001, op, rd[3], rs[3], rs[2:0], rd[2:0]};
    endfunction

    task automatic chk(input string req, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dut%0d %s actual=%h expected=%h", req, k, what, act, exp);
        end
    endtask

    task automatic rdreg(input int k, input logic [3:0] idx, output logic [31:0] val);
        dbg_sel = idx;
        #0.1;
        val = dbg_d[k];
    endtask

    // Starts and ends at a falling edge
    task automatic step(input logic [15:0] w, input logic v, input string brtag);
        logic [3:0]  rd;
        logic [3:0]  rs;
        logic [1:0]  op;
        logic        hit;
        logic        ud;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [32:0] d;
        logic [31:0] got;
        string       rtag;
        string       ftag;
        rd  = {w[7], w[2:0]};
        rs  = {w[6], w[5:3]};
        op  = w[9:8];
        hit = v && (w[15:10] == 6'b010001);
        ud  = hit && (op != 2'b11) && !w[7] && !w[6];
        for (int k = 0; k < 2; k++) begin
            a = (rd == 4'd15) ? mreg[k][15] + ahead(k) : mreg[k][rd];
            b = (rs == 4'd15) ? mreg[k][15] + ahead(k) : mreg[k][rs];
            e_br[k]  = 1'b0;
            e_und[k] = ud;
            e_tgt[k] = '0;
            if (hit && !ud) begin
                case (op)
                    2'b00, 2'b10: begin
                        r = (op == 2'b00) ? a + b : b;
                        if (rd == 4'd15) begin
                            r[0] = 1'b0;
                            e_br[k] = 1'b1;
                            e_tgt[k] = r;
                        end
                        mreg[k][rd] = r;
                    end
                    2'b01: begin
                        d = {1'b0, a} - {1'b0, b};
                        mfl[k] = {d[31], d[31:0] == 32'd0, !d[32],
                                  (a[31] != b[31]) && (d[31] != a[31])};
                    end
                    default: begin
                        mst[k] = b[0];
                        r = b & (b[0] ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
                        mreg[k][15] = r;
                        e_br[k] = 1'b1;
                        e_tgt[k] = r;
                    end
                endcase
            end
        end
        instr_valid = v;
        instr_word  = w;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        if (!hit) begin
            rtag = "R1"; ftag = "R1";
        end else begin
            ftag = (op == 2'b01) ? "R5" : "R6";
            if (ud)                                    rtag = "R7";
            else if (op == 2'b11)                      rtag = "R8";
            else if (op != 2'b01 && rd == 4'd15)       rtag = "R10";
            else if (rs == 4'd15 || rd == 4'd15)       rtag = "R9";
            else if (op == 2'b01)                      rtag = "R5";
            else if (rd[3] != rs[3])                   rtag = "R2";
            else if (op == 2'b00)                      rtag = "R3";
            else                                       rtag = "R4";
        end
        for (int k = 0; k < 2; k++) begin
            chk((brtag != "") ? brtag : rtag, k, "branch_taken", 32'(brt[k]), 32'(e_br[k]));
            if (e_br[k]) chk(rtag, k, "branch_target", tgt[k], e_tgt[k]);
            chk(ud ? "R7" : rtag, k, "undef_flag", 32'(und[k]), 32'(e_und[k]));
            chk(ud ? "R7" : ftag, k, "flags", 32'(fl[k]), 32'(mfl[k]));
            chk((op == 2'b11 && hit) ? "R8" : rtag, k, "state", 32'(stc[k]), 32'(mst[k]));
            rdreg(k, rd, got);
            chk(rtag, k, "dest reg", got, mreg[k][rd]);
            rdreg(k, 4'd15, got);
            chk(rtag, k, "r15", got, mreg[k][15]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] got;
        rst = 1'b1;
        instr_valid = 1'b0;
        instr_word = '0;
        dbg_sel = '0;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) mreg[k][i] = '0;
            mfl[k] = '0;
            mst[k] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) begin
                rdreg(k, 4'(i), got);
                chk("R11", k, "reset reg", got, 32'd0);
            end
            chk("R11", k, "reset flags", 32'(fl[k]), 32'd0);
            chk("R11", k, "reset state", 32'(stc[k]), 32'd1);
            chk("R11", k, "reset branch", 32'(brt[k]), 32'd0);
            chk("R11", k, "reset undef", 32'(und[k]), 32'd0);
        end
        @(negedge clk);

        // R2 / R9: high-register moves from the program counter
        step(enc(2'b10, 4'd9, 4'd15), 1'b1, "");
        step(enc(2'b10, 4'd1, 4'd9), 1'b1, "");
        step(enc(2'b00, 4'd12, 4'd1), 1'b1, "");

        // R1: foreign prefixes and a dropped strobe
        for (int p = 0; p < 64; p++) begin
            if (p != 17) step({6'(p), 10'(p * 37 + 5)}, 1'b1, "");
        end
        step(enc(2'b00, 4'd9, 4'd9), 1'b0, "");

        // R12: branch pulse lasts one cycle
        step(enc(2'b11, 4'd0, 4'd9), 1'b1, "");
        step(16'h0000, 1'b0, "R12");

        // Full sweeps of the encoding space
        for (int o = 0; o < 5; o++) begin
            for (int rd = 0; rd < 16; rd++) begin
                for (int rs = 0; rs < 16; rs++) begin
                    step(enc((o == 4) ? 2'b01 : 2'(o), 4'(rd), 4'(rs)), 1'b1, "");
                end
            end
        end
        step(16'h0000, 1'b0, "R12");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule